// File: doc/BRIEF.md
# Pixel Offset-Subtract and Gain-Multiply Stage

This stage takes a stream of 12-bit pixels that have already had their odd/even correction. For each pixel it subtracts a per-pixel offset and then multiplies the result by a per-pixel gain. The offset and the gain are not part of the pixel stream. They arrive on two free-running buses. The block samples those buses on every clock edge where its pipeline moves. It holds each sampled pair for a fixed number of transfer edges, so that the pair meets the pixel it is meant for.

Three plain configuration inputs control how the bus words are read. One sets the offset word width (8, 9 or 10 bits). One sets the gain word width (10, 11 or 12 bits). A 3-bit selector sets the full-scale gain. A gain code of zero is always unity. The full code range spreads the gain evenly from 1× up to the selected maximum.

The pixel stream uses valid/ready on both sides. A pixel is accepted on an edge where `in_valid` and `in_ready` are both high. The result leaves on an edge where `out_valid` and `out_ready` are both high. When the output is stalled (`out_valid` high and `out_ready` low), the whole pipeline freezes. This includes bus sampling, and `in_ready` drops in the same cycle. While the output is not stalled, `in_ready` is high, and the stage accepts one pixel per clock.

Top module: `pxcor_offset_gain`

## Requirements
- R1: While reset is applied and just after it is released, `out_valid` is 0 and `in_ready` is 1. The captured offset and gain pairs reset to offset 0 and gain code 0.
- R2: The offset code is masked to its configured width before use. `cfg_off_w` 0 selects 8 bits, 1 selects 9 bits, and 2 or 3 select 10 bits. The masked code, read as straight binary, is subtracted from the pixel.
- R3: A subtraction result below zero becomes 0.
- R4: A masked gain code of 0 passes the difference through unchanged (exactly 1×).
- R5: For a difference d and a masked gain code g, the output is d + floor(d·g·(s+1) / 2^N). Here s is `cfg_gmax` (full-scale gain s+2) and N is the gain width. `cfg_gain_w` 0 selects N=10, 1 selects N=11, and 2 or 3 select N=12.
- R6: An output above 4095 becomes 4095.
- R7: Gain bus bits above the configured width have no effect on the result.
- R8: An offset/gain pair is sampled with the configuration inputs on a transfer edge. It applies to the pixel accepted BUS_LEAD (default 3) transfer edges later. A transfer edge is any edge with `in_ready` high.
- R9: A pixel accepted on edge k into an empty, unstalled pipeline makes `out_valid` high after edge k+2, and not before.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is 0, and `out_valid` and `out_data` hold on the next edge. Every accepted pixel leaves exactly once, in order.
- R11: Edges without an accepted pixel produce no output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Stage can accept a pixel on this edge |
| in_data | input | PIX_W | Odd/even-corrected pixel |
| off_bus | input | OFF_W | Offset code bus, straight binary |
| gain_bus | input | GAIN_W | Gain code bus, straight binary |
| cfg_off_w | input | 2 | Offset word width select |
| cfg_gain_w | input | 2 | Gain word width select |
| cfg_gmax | input | GSEL_W | Full-scale gain select |
| out_valid | output | 1 | Corrected pixel valid |
| out_ready | input | 1 | Downstream accepts the pixel |
| out_data | output | PIX_W | Corrected pixel |

## Verification
The offset path is tried with an all-ones bus word under each width setting. This shows the three widths apart, and shows that setting 3 acts as the widest. Words with bits set only above the configured width check the masking. Negative differences and the boundary at exactly zero check the clamp. Gain is tried with code zero, mid-scale and full-scale codes across several widths and selectors, so that a wrong shift, a wrong multiplier or a missing unity term each give a distinct value. Full-scale products check saturation. A back-to-back stream whose offset, gain and configuration change on every edge shows whether the bus words line up with the right pixel. Streams with gaps and with irregular output stalls show loss, duplication or drift in the alignment.

// File: rtl/pxcor_pkg.sv
package pxcor_pkg;
  typedef logic [1:0] wsel_t;

  // number of upper bits dropped from a bus word for a width select
  function automatic logic [1:0] trim_of(wsel_t sel);
    case (sel)
      2'd0:    trim_of = 2'd2;
      2'd1:    trim_of = 2'd1;
      default: trim_of = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/pxcor_bus_delay.sv
module pxcor_bus_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   stg[i] <= '0;
      else if (adv) stg[i] <= (i == 0) ? d : stg[(i == 0) ? 0 : i - 1];
    end
  end

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/pxcor_sub_stage.sv
module pxcor_sub_stage #(
  parameter int PIX_W   = 12,
  parameter int OFF_W   = 10,
  parameter int CARRY_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic               in_valid,
  input  logic [PIX_W-1:0]   in_data,
  input  logic [OFF_W-1:0]   off,
  input  logic [CARRY_W-1:0] carry_in,
  output logic               v,
  output logic [PIX_W-1:0]   diff,
  output logic [CARRY_W-1:0] carry_out
);
  localparam int EW = ((PIX_W > OFF_W) ? PIX_W : OFF_W) + 1;

  logic [EW-1:0]    a_ext, b_ext, d_ext;
  logic [PIX_W-1:0] d_clamped;

  always_comb begin
    a_ext     = EW'(in_data);
    b_ext     = EW'(off);
    d_ext     = a_ext - b_ext;
    d_clamped = (a_ext >= b_ext) ? d_ext[PIX_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v         <= 1'b0;
      diff      <= '0;
      carry_out <= '0;
    end else if (adv) begin
      v         <= in_valid;
      diff      <= d_clamped;
      carry_out <= carry_in;
    end
  end
endmodule

// File: rtl/pxcor_gain_stage.sv
module pxcor_gain_stage #(
  parameter int PIX_W  = 12,
  parameter int GAIN_W = 12,
  parameter int GSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              v1,
  input  logic [PIX_W-1:0]  d1,
  input  logic [GAIN_W-1:0] gcode1,
  input  logic [GSEL_W-1:0] gsel1,
  input  logic [1:0]        gtrim1,
  output logic              v2,
  output logic [PIX_W-1:0]  d2,
  output logic [GAIN_W-1:0] gcode2,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_data
);
  localparam int MW  = GSEL_W + 1;
  localparam int PW  = PIX_W + GAIN_W + MW;
  localparam int SHW = $clog2(GAIN_W + 1);

  logic [MW-1:0]  mult1;
  logic [PW-1:0]  prod2, inc2;
  logic [PW:0]    sum2;
  logic [1:0]     trim2;
  logic [SHW-1:0] shamt2;
  logic [PIX_W-1:0] sat2;

  assign mult1 = MW'(gsel1) + MW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2     <= 1'b0;
      d2     <= '0;
      gcode2 <= '0;
      prod2  <= '0;
      trim2  <= '0;
    end else if (adv) begin
      v2     <= v1;
      d2     <= d1;
      gcode2 <= gcode1;
      prod2  <= PW'(d1) * PW'(gcode1) * PW'(mult1);
      trim2  <= gtrim1;
    end
  end

  always_comb begin
    shamt2 = SHW'(GAIN_W) - SHW'(trim2);
    inc2   = prod2 >> shamt2;
    sum2   = (PW+1)'(d2) + (PW+1)'(inc2);
    sat2   = (sum2[PW:PIX_W] != '0) ? {PIX_W{1'b1}} : sum2[PIX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (adv) begin
      out_valid <= v2;
      out_data  <= sat2;
    end
  end
endmodule

// File: rtl/pxcor_offset_gain.sv
module pxcor_offset_gain
  import pxcor_pkg::*;
#(
  parameter int PIX_W    = 12,
  parameter int OFF_W    = 10,
  parameter int GAIN_W   = 12,
  parameter int GSEL_W   = 3,
  parameter int BUS_LEAD = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PIX_W-1:0]  in_data,
  input  logic [OFF_W-1:0]  off_bus,
  input  logic [GAIN_W-1:0] gain_bus,
  input  logic [1:0]        cfg_off_w,
  input  logic [1:0]        cfg_gain_w,
  input  logic [GSEL_W-1:0] cfg_gmax,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIX_W-1:0]  out_data
);
  localparam int CARRY_W = 2 + GSEL_W + GAIN_W;
  localparam int TAP_W   = CARRY_W + OFF_W;

  logic                adv;
  logic [OFF_W-1:0]    off_m;
  logic [GAIN_W-1:0]   gain_m;
  logic [TAP_W-1:0]    tap_in, tap_out;
  logic [OFF_W-1:0]    tap_off;
  logic [CARRY_W-1:0]  tap_carry, s1_carry;
  logic                s1_v, s2_v;
  logic [PIX_W-1:0]    s1_diff, s2_diff;
  logic [GAIN_W-1:0]   s1_gcode, s2_gcode;
  logic [GSEL_W-1:0]   s1_gsel;
  logic [1:0]          s1_gtrim;

  // the whole pipe moves unless the output word is refused
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  assign off_m  = off_bus  & ({OFF_W{1'b1}}  >> trim_of(cfg_off_w));
  assign gain_m = gain_bus & ({GAIN_W{1'b1}} >> trim_of(cfg_gain_w));
  assign tap_in = {trim_of(cfg_gain_w), cfg_gmax, gain_m, off_m};

  pxcor_bus_delay #(.W(TAP_W), .DEPTH(BUS_LEAD)) u_bus_delay (
    .clk(clk), .rst_n(rst_n), .adv(adv), .d(tap_in), .q(tap_out)
  );

  assign tap_off   = tap_out[OFF_W-1:0];
  assign tap_carry = tap_out[TAP_W-1:OFF_W];

  pxcor_sub_stage #(.PIX_W(PIX_W), .OFF_W(OFF_W), .CARRY_W(CARRY_W)) u_sub (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .in_valid(in_valid && in_ready), .in_data(in_data), .off(tap_off),
    .carry_in(tap_carry), .v(s1_v), .diff(s1_diff), .carry_out(s1_carry)
  );

  assign s1_gcode = s1_carry[GAIN_W-1:0];
  assign s1_gsel  = s1_carry[GAIN_W +: GSEL_W];
  assign s1_gtrim = s1_carry[CARRY_W-1 -: 2];

  pxcor_gain_stage #(.PIX_W(PIX_W), .GAIN_W(GAIN_W), .GSEL_W(GSEL_W)) u_gain (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .v1(s1_v), .d1(s1_diff), .gcode1(s1_gcode), .gsel1(s1_gsel), .gtrim1(s1_gtrim),
    .v2(s2_v), .d2(s2_diff), .gcode2(s2_gcode),
    .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: rtl/pxcor_checker.sv
module pxcor_checker #(
  parameter int PIX_W  = 12,
  parameter int OFF_W  = 10,
  parameter int GAIN_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [PIX_W-1:0]  in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [PIX_W-1:0]  out_data,
  input logic              adv,
  input logic [OFF_W-1:0]  tap_off,
  input logic              s1_v,
  input logic [PIX_W-1:0]  s1_diff,
  input logic              s2_v,
  input logic [PIX_W-1:0]  s2_diff,
  input logic [GAIN_W-1:0] s2_gcode
);
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R10
  AST_NO_ACCEPT_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R10
  AST_SUB_NOT_ABOVE_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (s1_v && s1_diff <= $past(in_data))); // R3
  AST_ZERO_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && tap_off == '0) |=> (s1_diff == $past(in_data))); // R2
  AST_UNITY_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && s2_v && s2_gcode == '0) |=> (out_data == $past(s2_diff))); // R4
  AST_GAIN_NOT_BELOW_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && s2_v) |=> (out_data >= $past(s2_diff))); // R5
  AST_BUBBLE_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !s2_v) |=> !out_valid); // R11
endmodule

bind pxcor_offset_gain pxcor_checker #(
  .PIX_W(PIX_W), .OFF_W(OFF_W), .GAIN_W(GAIN_W)
) u_pxcor_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .adv(adv), .tap_off(tap_off), .s1_v(s1_v),
  .s1_diff(s1_diff), .s2_v(s2_v), .s2_diff(s2_diff), .s2_gcode(s2_gcode)
);

// File: tb/test_pxcor_offset_gain.sv
module test_pxcor_offset_gain;
  localparam int LEAD = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] in_data = '0;
  logic [9:0]  off_bus = '0;
  logic [11:0] gain_bus = '0;
  logic [1:0]  cfg_off_w = '0;
  logic [1:0]  cfg_gain_w = '0;
  logic [2:0]  cfg_gmax = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [11:0] out_data;

  int ntot = 0;
  int nbad = 0;

  // history of bus words per transfer edge
  int h_off[4096], h_gain[4096], h_ow[4096], h_gw[4096], h_gs[4096];
  int nb = 0;
  // expected output queue
  int    e_val[1024];
  string e_tag[1024];
  int    e_head = 0, e_tail = 0;

  always #5 clk = ~clk;

  pxcor_offset_gain i_pxcor_offset_gain (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .off_bus(off_bus), .gain_bus(gain_bus),
    .cfg_off_w(cfg_off_w), .cfg_gain_w(cfg_gain_w), .cfg_gmax(cfg_gmax),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic int model(int pix, int off, int gain, int ow, int gw, int gs);
    int ob, gb;
    longint d, g, p;
    ob = (ow == 0) ? 8 : (ow == 1) ? 9 : 10;
    gb = (gw == 0) ? 10 : (gw == 1) ? 11 : 12;
    d = longint'(pix) - longint'(off & ((1 << ob) - 1));
    if (d < 0) d = 0;
    g = longint'(gain & ((1 << gb) - 1));
    p = d + ((d * g * longint'(gs + 1)) >>> gb);
    if (p > 4095) p = 4095;
    return int'(p);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    ntot++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock: called at a falling edge, returns at the next falling edge
  task automatic step(input bit iv, input int pix, input int off, input int gain,
                      input int ow, input int gw, input int gs, input bit ordy,
                      input string tag);
    bit stall;
    int held, idx, eo, eg, eow, egw, egs;
    in_valid = iv; in_data = pix[11:0]; off_bus = off[9:0]; gain_bus = gain[11:0];
    cfg_off_w = ow[1:0]; cfg_gain_w = gw[1:0]; cfg_gmax = gs[2:0]; out_ready = ordy;
    #1;
    if (out_valid && out_ready) begin
      if (e_head == e_tail) chk("R10 unexpected output word", 1, 0);
      else begin
        chk(e_tag[e_head], int'(out_data), e_val[e_head]);
        e_head++;
      end
    end
    stall = out_valid && !out_ready;
    held  = int'(out_data);
    if (stall) chk("R10 in_ready low in stall", int'(in_ready), 0);
    if (in_ready) begin
      h_off[nb] = off; h_gain[nb] = gain; h_ow[nb] = ow; h_gw[nb] = gw; h_gs[nb] = gs;
      nb++;
      if (iv) begin
        idx = nb - 1 - LEAD;
        if (idx < 0) begin eo = 0; eg = 0; eow = 0; egw = 0; egs = 0; end
        else begin
          eo = h_off[idx]; eg = h_gain[idx]; eow = h_ow[idx]; egw = h_gw[idx]; egs = h_gs[idx];
        end
        e_val[e_tail] = model(pix, eo, eg, eow, egw, egs);
        e_tag[e_tail] = tag;
        e_tail++;
      end
    end
    @(posedge clk);
    @(negedge clk);
    if (stall) begin
      chk("R10 out_valid held", int'(out_valid), 1);
      chk("R10 out_data held", int'(out_data), held);
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 0, 0, 1, "drain");
  endtask

  // apply a constant bus word, then send one pixel under it
  task automatic one(input int pix, input int off, input int gain, input int ow,
                     input int gw, input int gs, input string tag);
    for (int i = 0; i < LEAD; i++) step(0, 0, off, gain, ow, gw, gs, 1, tag);
    step(1, pix, off, gain, ow, gw, gs, 1, tag);
    drain();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    #1;
    chk("R1 out_valid after reset", int'(out_valid), 0);
    chk("R1 in_ready after reset", int'(in_ready), 1);
    #1;
    // first pixels run under the reset-state bus pair
    step(1, 1234, 1023, 4095, 2, 2, 7, 1, "R1 reset pair");
    drain();
  endtask

  task automatic t_offset();
    for (int ow = 0; ow < 4; ow++) one(2000, 1023, 0, ow, 0, 0, "R2 offset width");
    one(2000, 'h300, 0, 0, 0, 0, "R2 offset upper bits masked");
    one(3000, 5, 0, 2, 0, 0, "R2 small offset");
  endtask

  task automatic t_clamp();
    one(100, 600, 0, 2, 0, 0, "R3 negative clamp");
    one(600, 600, 0, 2, 0, 0, "R3 exact zero");
    one(601, 600, 0, 2, 0, 0, "R3 just above");
  endtask

  task automatic t_unity();
    one(4095, 0, 0, 0, 2, 7, "R4 unity full pixel");
    one(777, 0, 0, 0, 0, 3, "R4 unity");
  endtask

  task automatic t_gain();
    one(1000, 0, 2048, 0, 2, 0, "R5 gain mid 12b");
    one(512, 0, 1023, 0, 0, 2, "R5 gain full 10b");
    one(300, 0, 1500, 0, 1, 4, "R5 gain 11b");
    one(1111, 10, 4000, 1, 3, 1, "R5 gain wsel3");
  endtask

  task automatic t_sat();
    one(4000, 0, 4095, 0, 2, 7, "R6 saturate");
    one(2048, 0, 4095, 0, 2, 0, "R6 near top");
  endtask

  task automatic t_mask();
    one(900, 0, 'hC00, 0, 0, 5, "R7 gain masked 10b");
    one(900, 0, 'h800, 0, 1, 5, "R7 gain masked 11b");
    one(900, 0, 'hC01, 0, 0, 5, "R7 gain low bit kept");
  endtask

  task automatic t_align();
    for (int i = 0; i < 16; i++)
      step(1, 400 + 211 * i, (i * 37) % 1024, (i * 517) % 4096, i % 4, (i / 2) % 4,
           i % 8, 1, "R8 per-edge alignment");
    drain();
  endtask

  task automatic t_latency();
    step(1, 500, 0, 0, 0, 0, 0, 1, "R9 latency word");
    chk("R9 not after k", int'(out_valid), 0);
    step(0, 0, 0, 0, 0, 0, 0, 1, "R9");
    chk("R9 not after k+1", int'(out_valid), 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, "R9");
    chk("R9 valid after k+2", int'(out_valid), 1);
    chk("R9 data", int'(out_data), 500);
    drain();
  endtask

  task automatic t_stall();
    for (int i = 0; i < 24; i++)
      step((i % 5) != 4, 100 + 150 * i, (i * 13) % 1024, (i * 301) % 4096, 2, 2,
           i % 8, (i % 3) != 1 && (i % 7) != 2, "R10 stall stream");
    drain();
    chk("R10 all words delivered", e_tail - e_head, 0);
  endtask

  task automatic t_bubble();
    for (int i = 0; i < 12; i++)
      step(i % 2, 50 * i + 7, i * 3, i * 100, 1, 1, 1, 1, "R11 bubble stream");
    drain();
    chk("R11 no extra words", e_tail - e_head, 0);
  endtask

  initial begin
    t_reset();
    t_offset();
    t_clamp();
    t_unity();
    t_gain();
    t_sat();
    t_mask();
    t_align();
    t_latency();
    t_stall();
    t_bubble();
    $display("  test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nbad++;
    ntot++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end
endmodule